// File: doc/BRIEF.md
# Microwire EEPROM Erase Engine

This block models the slave side of a small serial EEPROM on a three-wire Microwire link. It holds 64 words of 16 bits. Its command front end takes chip select, serial clock and data-in from the pins. It brings them into one system clock domain and shifts in a frame: a start bit, a two-bit opcode and a six-bit address. Two erase commands are modelled in full. The single-word erase forces one word to all ones, and the erase-all forces every word to all ones. Both are accepted only while a write-enable latch is set.

An erase does not start on a clock edge. It starts when chip select falls after a complete frame, and a self-timed counter of system clocks then runs it to the end. No serial clock is needed while it runs. When chip select is raised again after a minimum low time, the data-out pin reports status: 0 while busy and 1 when finished. A read command shifts a stored word out on the data-out pin, so the effect of an erase can be seen at the pins. Commands that write data are accepted and have no effect.

Top module: `mw_eeprom_erase`

## Requirements
- R1: After reset the data-out pin is not driven (`mw_do_oe` = 0), every word reads as 0x0000, the write-enable latch is clear and no erase is running.
- R2: Once a start bit has been taken and the remaining opcode and address bits are being shifted in, `mw_do_oe` stays 0.
- R3: Opcode 00 with the two upper address bits 11 sets the write-enable latch, and opcode 00 with upper bits 00 clears it. While the latch is clear, an erase frame leaves the array unchanged and no erase cycle starts.
- R4: The frame start bit 1, opcode 11, then six address bits sent most significant first, followed by a falling chip select, sets the addressed word to 0xFFFF and leaves every other word unchanged.
- R5: The frame start bit 1, opcode 00, upper address bits 10, with the four lower bits don't-care, followed by a falling chip select, sets every word to 0xFFFF.
- R6: If chip select falls before all eight opcode and address bits have been received, the frame is dropped and no erase cycle starts.
- R7: The erase stays busy for TWC_CYC system clocks for one word and TEC_CYC for the whole array, and it needs no serial clock edges. Seen at the pins, ready first appears TWC_CYC+3 (or TEC_CYC+3) clocks after chip select is driven low.
- R8: After an erase has been launched, raising chip select after a low time of at least TCSL_CYC clocks drives data-out with 0 while busy and 1 once the erase has finished.
- R9: A chip select low time shorter than TCSL_CYC clocks gives no status, and data-out stays undriven.
- R10: The status output stops being driven when chip select falls, or when a start bit is received after the erase has finished.
- R11: The frame start bit 1, opcode 10 and an address drives data-out with the stored word, most significant bit first. The first bit appears after the last address bit, and each further serial clock rising edge moves to the next bit.
- R12: While an erase is running, frames on data-in are ignored, and the write-enable latch and the array keep their state.
- R13: Zero bits on data-in before the start bit are skipped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mw_cs | input | 1 | Chip select pin, active high, asynchronous |
| mw_sclk | input | 1 | Serial clock pin, asynchronous |
| mw_di | input | 1 | Serial data-in pin, asynchronous |
| mw_do | output | 1 | Serial data-out value |
| mw_do_oe | output | 1 | Output enable for data-out; 0 means high impedance |

## Verification
Each pin passes through two synchronizer stages and an edge register. Busy therefore starts three system clocks after chip select is driven low, and status is enabled three clocks after chip select rises. Ready is checked at exactly DUR+3 clocks, counted from the clock where chip select was driven low. Read bits and the return to high impedance are settled about four clocks after the pin edge that causes them. The bench holds each serial clock level for six clocks and samples at the end of that hold. A per-clock monitor compares the output enable with the model's expectation while command bits are being shifted.

// File: rtl/mw_erase_pkg.sv
`timescale 1ns/1ps
package mw_erase_pkg;
  typedef enum logic [1:0] {
    OP_EXT   = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10,
    OP_ERASE = 2'b11
  } mw_op_e;

  // sub-codes carried in the two upper address bits of OP_EXT
  localparam logic [1:0] SUB_LOCK  = 2'b00;
  localparam logic [1:0] SUB_FILL  = 2'b01;
  localparam logic [1:0] SUB_WIPE  = 2'b10;
  localparam logic [1:0] SUB_OPEN  = 2'b11;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'b00,
    RX_SHIFT = 2'b01,
    RX_DONE  = 2'b10
  } rx_state_e;
endpackage

// File: rtl/mw_pin_sync.sv
`timescale 1ns/1ps
module mw_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_cs,
  input  logic pin_sclk,
  input  logic pin_di,
  output logic cs_lvl,
  output logic di_lvl,
  output logic cs_rise,
  output logic cs_fall,
  output logic sclk_rise
);
  logic [STAGES-1:0] cs_q, ck_q, di_q;
  logic              cs_d, ck_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q <= '0;
      ck_q <= '0;
      di_q <= '0;
      cs_d <= 1'b0;
      ck_d <= 1'b0;
    end else begin
      cs_q <= {cs_q[STAGES-2:0], pin_cs};
      ck_q <= {ck_q[STAGES-2:0], pin_sclk};
      di_q <= {di_q[STAGES-2:0], pin_di};
      cs_d <= cs_q[STAGES-1];
      ck_d <= ck_q[STAGES-1];
    end
  end

  assign cs_lvl    = cs_q[STAGES-1];
  assign di_lvl    = di_q[STAGES-1];
  assign cs_rise   = cs_q[STAGES-1] & ~cs_d;
  assign cs_fall   = ~cs_q[STAGES-1] & cs_d;
  assign sclk_rise = ck_q[STAGES-1] & ~ck_d;
endmodule

// File: rtl/mw_cmd_rx.sv
`timescale 1ns/1ps
module mw_cmd_rx
  import mw_erase_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_lvl,
  input  logic              sclk_rise,
  input  logic              di_lvl,
  input  logic              hold,
  output logic              start_seen,
  output logic              frame_vld,
  output mw_op_e            frame_op,
  output logic [ADDR_W-1:0] frame_addr
);
  localparam int FRAME_W = 2 + ADDR_W;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  rx_state_e          st_q, st_n;
  logic [CNT_W-1:0]   cnt_q, cnt_n;
  logic [FRAME_W-1:0] sh_q, sh_n;
  logic               vld_q, vld_n;
  logic               start_q, start_n;

  always_comb begin
    st_n    = st_q;
    cnt_n   = cnt_q;
    sh_n    = sh_q;
    vld_n   = 1'b0;
    start_n = 1'b0;
    if (!cs_lvl) begin
      st_n  = RX_IDLE;
      cnt_n = '0;
    end else if (sclk_rise) begin
      case (st_q)
        RX_IDLE: begin
          if (di_lvl && !hold) begin
            st_n    = RX_SHIFT;
            cnt_n   = '0;
            start_n = 1'b1;
          end
        end
        RX_SHIFT: begin
          sh_n  = {sh_q[FRAME_W-2:0], di_lvl};
          cnt_n = cnt_q + 1'b1;
          if (cnt_q == CNT_W'(FRAME_W - 1)) begin
            st_n  = RX_DONE;
            vld_n = 1'b1;
          end
        end
        default: st_n = st_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= RX_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      vld_q   <= 1'b0;
      start_q <= 1'b0;
    end else begin
      st_q    <= st_n;
      cnt_q   <= cnt_n;
      sh_q    <= sh_n;
      vld_q   <= vld_n;
      start_q <= start_n;
    end
  end

  assign start_seen = start_q;
  assign frame_vld  = vld_q;
  assign frame_op   = mw_op_e'(sh_q[FRAME_W-1 -: 2]);
  assign frame_addr = sh_q[ADDR_W-1:0];
endmodule

// File: rtl/mw_erase_timer.sv
`timescale 1ns/1ps
module mw_erase_timer #(
  parameter int TWC_CYC = 100000,
  parameter int TEC_CYC = 300000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic launch,
  input  logic launch_all,
  output logic busy,
  output logic done
);
  localparam int MAX_CYC = (TEC_CYC > TWC_CYC) ? TEC_CYC : TWC_CYC;
  localparam int CW      = $clog2(MAX_CYC + 1);

  logic          busy_q, busy_n;
  logic [CW-1:0] cnt_q, cnt_n;

  always_comb begin
    busy_n = busy_q;
    cnt_n  = cnt_q;
    if (busy_q) begin
      if (cnt_q == '0) busy_n = 1'b0;
      else             cnt_n  = cnt_q - 1'b1;
    end else if (launch) begin
      busy_n = 1'b1;
      cnt_n  = launch_all ? CW'(TEC_CYC - 1) : CW'(TWC_CYC - 1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_n;
      cnt_q  <= cnt_n;
    end
  end

  assign busy = busy_q;
  assign done = busy_q && (cnt_q == '0);
endmodule

// File: rtl/mw_word_array.sv
`timescale 1ns/1ps
module mw_word_array #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wipe_word,
  input  logic              wipe_all,
  input  logic [ADDR_W-1:0] wipe_addr,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < DEPTH; w++) mem_q[w] <= '0;
    end else begin
      for (int w = 0; w < DEPTH; w++) begin
        if (wipe_all || (wipe_word && (wipe_addr == ADDR_W'(w))))
          mem_q[w] <= '1;
      end
    end
  end

  assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/mw_eeprom_erase.sv
`timescale 1ns/1ps
module mw_eeprom_erase
  import mw_erase_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2,
  parameter int TCSL_CYC    = 13,
  parameter int TWC_CYC     = 100000,
  parameter int TEC_CYC     = 300000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mw_cs,
  input  logic mw_sclk,
  input  logic mw_di,
  output logic mw_do,
  output logic mw_do_oe
);
  localparam int LOW_CW = $clog2(TCSL_CYC + 1);

  logic              cs_lvl, di_lvl, cs_rise, cs_fall, sclk_rise;
  logic              start_seen, frame_vld;
  mw_op_e            frame_op;
  logic [ADDR_W-1:0] frame_addr;
  logic              busy, done, launch;
  logic [DATA_W-1:0] rd_data;

  logic              wen_q, wen_n;
  logic              pend_q, pend_n;
  logic              pend_all_q, pend_all_n;
  logic [ADDR_W-1:0] pend_addr_q, pend_addr_n;
  logic              eng_all_q, eng_all_n;
  logic [ADDR_W-1:0] eng_addr_q, eng_addr_n;
  logic              armed_q, armed_n;
  logic              status_q, status_n;
  logic              read_q, read_n;
  logic [DATA_W-1:0] rd_sh_q, rd_sh_n;
  logic [LOW_CW-1:0] lowcnt_q, lowcnt_n;

  mw_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .pin_cs(mw_cs), .pin_sclk(mw_sclk), .pin_di(mw_di),
    .cs_lvl(cs_lvl), .di_lvl(di_lvl),
    .cs_rise(cs_rise), .cs_fall(cs_fall), .sclk_rise(sclk_rise)
  );

  mw_cmd_rx #(.ADDR_W(ADDR_W)) u_rx (
    .clk(clk), .rst_n(rst_n),
    .cs_lvl(cs_lvl), .sclk_rise(sclk_rise), .di_lvl(di_lvl), .hold(busy),
    .start_seen(start_seen), .frame_vld(frame_vld),
    .frame_op(frame_op), .frame_addr(frame_addr)
  );

  mw_erase_timer #(.TWC_CYC(TWC_CYC), .TEC_CYC(TEC_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n),
    .launch(launch), .launch_all(pend_all_q),
    .busy(busy), .done(done)
  );

  mw_word_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk(clk), .rst_n(rst_n),
    .wipe_word(done && !eng_all_q), .wipe_all(done && eng_all_q),
    .wipe_addr(eng_addr_q),
    .rd_addr(frame_addr), .rd_data(rd_data)
  );

  assign launch = cs_fall && pend_q && !busy;

  always_comb begin
    wen_n       = wen_q;
    pend_n      = pend_q;
    pend_all_n  = pend_all_q;
    pend_addr_n = pend_addr_q;
    eng_all_n   = eng_all_q;
    eng_addr_n  = eng_addr_q;
    armed_n     = armed_q;
    status_n    = status_q;
    read_n      = read_q;
    rd_sh_n     = rd_sh_q;
    lowcnt_n    = lowcnt_q;

    // chip-select low time, saturating at the threshold
    if (cs_lvl)                             lowcnt_n = '0;
    else if (lowcnt_q < LOW_CW'(TCSL_CYC))  lowcnt_n = lowcnt_q + 1'b1;

    // decoded frame
    if (frame_vld && !busy) begin
      case (frame_op)
        OP_EXT: begin
          case (frame_addr[ADDR_W-1 -: 2])
            SUB_OPEN: wen_n = 1'b1;
            SUB_LOCK: wen_n = 1'b0;
            SUB_WIPE: begin
              if (wen_q) begin
                pend_n     = 1'b1;
                pend_all_n = 1'b1;
              end
            end
            default: wen_n = wen_q;
          endcase
        end
        OP_ERASE: begin
          if (wen_q) begin
            pend_n      = 1'b1;
            pend_all_n  = 1'b0;
            pend_addr_n = frame_addr;
          end
        end
        OP_READ: begin
          read_n  = 1'b1;
          rd_sh_n = rd_data;
        end
        default: read_n = read_q;
      endcase
    end else if (read_q && sclk_rise) begin
      rd_sh_n = {rd_sh_q[DATA_W-2:0], 1'b0};
    end

    // status window
    if (cs_rise && armed_q && (lowcnt_q >= LOW_CW'(TCSL_CYC))) status_n = 1'b1;
    if (start_seen) begin
      status_n = 1'b0;
      armed_n  = 1'b0;
    end

    // chip select falling: launch or abort, close outputs
    if (cs_fall) begin
      pend_n   = 1'b0;
      read_n   = 1'b0;
      status_n = 1'b0;
    end
    if (launch) begin
      eng_all_n  = pend_all_q;
      eng_addr_n = pend_addr_q;
      armed_n    = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wen_q       <= 1'b0;
      pend_q      <= 1'b0;
      pend_all_q  <= 1'b0;
      pend_addr_q <= '0;
      eng_all_q   <= 1'b0;
      eng_addr_q  <= '0;
      armed_q     <= 1'b0;
      status_q    <= 1'b0;
      read_q      <= 1'b0;
      rd_sh_q     <= '0;
      lowcnt_q    <= '0;
    end else begin
      wen_q       <= wen_n;
      pend_q      <= pend_n;
      pend_all_q  <= pend_all_n;
      pend_addr_q <= pend_addr_n;
      eng_all_q   <= eng_all_n;
      eng_addr_q  <= eng_addr_n;
      armed_q     <= armed_n;
      status_q    <= status_n;
      read_q      <= read_n;
      rd_sh_q     <= rd_sh_n;
      lowcnt_q    <= lowcnt_n;
    end
  end

  assign mw_do_oe = status_q | read_q;
  assign mw_do    = status_q ? ~busy : rd_sh_q[DATA_W-1];
endmodule

// File: rtl/mw_eeprom_erase_chk.sv
`timescale 1ns/1ps
module mw_eeprom_erase_chk #(
  parameter int TWC_CYC = 100000,
  parameter int TEC_CYC = 300000
) (
  input logic clk,
  input logic rst_n,
  input logic cs_fall,
  input logic busy,
  input logic done,
  input logic eng_all_q,
  input logic wen_q,
  input logic pend_q,
  input logic read_q,
  input logic mw_do,
  input logic mw_do_oe
);
  logic [31:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_cnt <= '0;
    else if (busy) run_cnt <= run_cnt + 1;
    else           run_cnt <= '0;
  end

  // R7
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (run_cnt == (eng_all_q ? 32'(TEC_CYC - 1) : 32'(TWC_CYC - 1))));

  // R4
  launch_on_cs_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cs_fall));

  // R6
  launch_needs_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(pend_q));

  // R3
  pending_needs_wen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> wen_q);

  // R10
  cs_fall_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_fall |=> !mw_do_oe);

  // R8
  status_busy_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mw_do_oe && busy) |-> !mw_do);

  // R12
  no_read_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !read_q);
endmodule

bind mw_eeprom_erase mw_eeprom_erase_chk #(.TWC_CYC(TWC_CYC), .TEC_CYC(TEC_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_fall(cs_fall), .busy(busy), .done(done),
  .eng_all_q(eng_all_q), .wen_q(wen_q), .pend_q(pend_q), .read_q(read_q),
  .mw_do(mw_do), .mw_do_oe(mw_do_oe)
);

// File: tb/test_mw_eeprom_erase.sv
`timescale 1ns/1ps
module test_mw_eeprom_erase;
  localparam int AW = 6, DW = 16, FW = 2 + AW;
  localparam int TCSL = 13, TWC = 200, TEC = 400;

  logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, sclk = 1'b0, di = 1'b0;
  logic dout, doe;

  always #10 clk = ~clk;

  mw_eeprom_erase #(.ADDR_W(AW), .DATA_W(DW), .TCSL_CYC(TCSL),
                    .TWC_CYC(TWC), .TEC_CYC(TEC)) i_mw_eeprom_erase (
    .clk(clk), .rst_n(rst_n), .mw_cs(cs), .mw_sclk(sclk), .mw_di(di),
    .mw_do(dout), .mw_do_oe(doe)
  );

  int checks = 0, fails = 0;
  bit exp_hiz = 1'b0;
  logic [DW-1:0] exp_mem [1 << AW];

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R2: reference expectation compared on every clock while command bits shift
  always @(negedge clk) if (exp_hiz) chk("R2 data-out undriven while shifting", doe, 1'b0);

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put_bit(logic b);
    di = b; wait_clk(2);
    sclk = 1'b1; wait_clk(6);
    sclk = 1'b0; wait_clk(6);
  endtask

  task automatic cs_open();
    cs = 1'b1; wait_clk(4);
  endtask

  task automatic send_frame(logic [1:0] op, logic [AW-1:0] a, int nbits, bit quiet, bit with_start);
    logic [FW-1:0] fr;
    fr = {op, a};
    if (with_start) put_bit(1'b1);
    if (quiet) exp_hiz = 1'b1;
    for (int i = 0; i < nbits; i++) begin
      if (i == nbits - 1) exp_hiz = 1'b0;
      put_bit(fr[FW-1-i]);
    end
    exp_hiz = 1'b0;
  endtask

  task automatic read_rest(string req, logic [AW-1:0] a);
    logic [DW-1:0] v;
    for (int i = 0; i < DW; i++) begin
      if (i > 0) begin
        sclk = 1'b1; wait_clk(6);
        sclk = 1'b0; wait_clk(6);
      end
      if (doe !== 1'b1) chk("R11 read drives data-out", doe, 1'b1);
      v[DW-1-i] = dout;
    end
    chk(req, v, exp_mem[a]);
    cs = 1'b0; wait_clk(6);
  endtask

  task automatic check_word(string req, logic [AW-1:0] a);
    cs_open();
    send_frame(2'b10, a, FW, 1'b1, 1'b1);
    read_rest(req, a);
  endtask

  // drop CS to launch, reopen after a valid low time, time the ready flag
  task automatic measure(int dur, string req);
    int k = 0, ready_k = -1;
    bit seen = 1'b0;
    cs = 1'b0;
    while (ready_k < 0 && k < 3000) begin
      @(negedge clk); k++;
      if (k == 20) cs = 1'b1;
      if (doe && !seen) begin
        seen = 1'b1;
        chk("R8 status shows busy", dout, 1'b0);
      end
      if (seen && doe && dout) ready_k = k;
    end
    chk(req, ready_k, dur + 3);
    cs = 1'b0; wait_clk(5);
    chk("R10 status released on CS fall", doe, 1'b0);
    wait_clk(3);
  endtask

  task automatic no_status(string req);
    cs = 1'b0; wait_clk(20);
    cs = 1'b1; wait_clk(8);
    chk(req, doe, 1'b0);
    cs = 1'b0; wait_clk(6);
  endtask

  initial begin
    #3000000;
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int w = 0; w < (1 << AW); w++) exp_mem[w] = '0;
    wait_clk(5); rst_n = 1'b1; wait_clk(5);

    // R1 reset state
    chk("R1 data-out undriven after reset", doe, 1'b0);
    check_word("R1 array cleared by reset", 6'd5);

    // R3 erase refused while latch clear
    cs_open(); send_frame(2'b11, 6'd5, FW, 1'b1, 1'b1);
    no_status("R3 no erase cycle without enable");
    check_word("R3 word kept without enable", 6'd5);

    // enable, then word erase
    cs_open(); send_frame(2'b00, 6'b110000, FW, 1'b1, 1'b1); cs = 1'b0; wait_clk(6);
    cs_open(); send_frame(2'b11, 6'd5, FW, 1'b1, 1'b1);
    measure(TWC, "R7 word erase duration");
    exp_mem[5] = '1;
    check_word("R4 addressed word erased", 6'd5);
    check_word("R4 lower neighbour kept", 6'd4);
    check_word("R4 upper neighbour kept", 6'd6);

    // R13 leading zeros
    cs_open(); put_bit(1'b0); put_bit(1'b0);
    send_frame(2'b11, 6'd63, FW, 1'b1, 1'b1);
    measure(TWC, "R13 erase after leading zeros");
    exp_mem[63] = '1;
    check_word("R13 word 63 erased", 6'd63);

    // R6 aborted frame
    cs_open(); send_frame(2'b11, 6'd2, 5, 1'b1, 1'b1);
    no_status("R6 short frame starts no cycle");
    check_word("R6 word 2 kept", 6'd2);

    // R9 short low time
    cs_open(); send_frame(2'b11, 6'd10, FW, 1'b1, 1'b1);
    cs = 1'b0; wait_clk(6);
    cs = 1'b1; wait_clk(10);
    chk("R9 no status after short low", doe, 1'b0);
    cs = 1'b0; wait_clk(20);
    cs = 1'b1; wait_clk(6);
    chk("R8 status driven after valid low", doe, 1'b1);
    for (int i = 0; i < 400 && dout !== 1'b1; i++) wait_clk(1);
    chk("R8 ready reported", dout, 1'b1);
    cs = 1'b0; wait_clk(6);
    exp_mem[10] = '1;
    check_word("R4 word 10 erased", 6'd10);

    // R12 frames ignored while busy
    cs_open(); send_frame(2'b11, 6'd20, FW, 1'b1, 1'b1);
    cs = 1'b0; wait_clk(20);
    cs = 1'b1; wait_clk(6);
    chk("R8 busy during erase", dout, 1'b0);
    send_frame(2'b00, 6'b000000, FW, 1'b0, 1'b1);
    chk("R12 status kept during ignored frame", doe, 1'b1);
    cs = 1'b0; wait_clk(6);
    chk("R10 released on CS fall", doe, 1'b0);
    wait_clk(120);
    exp_mem[20] = '1;
    cs_open(); send_frame(2'b11, 6'd21, FW, 1'b1, 1'b1);
    measure(TWC, "R12 enable latch kept through busy");
    exp_mem[21] = '1;

    // R10 start bit ends status
    cs = 1'b0; wait_clk(20);
    cs = 1'b1; wait_clk(6);
    chk("R8 ready status", dout, 1'b1);
    put_bit(1'b1);
    chk("R10 start bit releases data-out", doe, 1'b0);
    send_frame(2'b10, 6'd21, FW, 1'b1, 1'b0);
    read_rest("R11 read of word 21", 6'd21);
    check_word("R12 word 20 erased", 6'd20);

    // R3 lock then erase has no effect
    cs_open(); send_frame(2'b00, 6'b000000, FW, 1'b1, 1'b1); cs = 1'b0; wait_clk(6);
    cs_open(); send_frame(2'b11, 6'd30, FW, 1'b1, 1'b1);
    no_status("R3 locked erase starts no cycle");
    check_word("R3 word 30 kept when locked", 6'd30);

    // R5 erase-all
    cs_open(); send_frame(2'b00, 6'b110000, FW, 1'b1, 1'b1); cs = 1'b0; wait_clk(6);
    cs_open(); send_frame(2'b00, 6'b101011, FW, 1'b1, 1'b1);
    measure(TEC, "R7 erase-all duration");
    for (int w = 0; w < (1 << AW); w++) exp_mem[w] = '1;
    check_word("R5 word 0 erased", 6'd0);
    check_word("R5 word 31 erased", 6'd31);
    check_word("R5 word 62 erased", 6'd62);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule